// File: doc/BRIEF.md
# Performance Monitor Counter Register File

This block is a register-mapped performance monitor. It holds up to `HW_LIMIT` general event counters and one free-running cycle counter. Software reaches every register through a single-beat register bus: a global control word, three set/clear bitmap pairs (count enable, interrupt enable, overflow status), one count register and one event-type register per counter, and a select register that opens indirect count and type windows onto one counter. A side configuration port can load any bitmap whole.

The number of implemented event counters is a run-time field of the control word. Bitmap bits of counters at or above that number are held at zero. A count or type access to such a counter, whether direct or through the select window, ends in an error response and changes nothing. Event strobes drive the counters, and a single interrupt line reports overflow.

The bus accepts a request on every cycle in which `req_valid` is high. It applies no back-pressure, so the bus has no ready signal. Exactly one response beat (`rsp_valid`) follows each request on the next cycle.

Top module: `pmu_regfile`

Register map (byte-free word addresses): 0x00 control (bit 0 enable, bit 1 clear-all-event-counters, write-only and reads 0, bits 12:8 implemented count), 0x01/0x02 count-enable set/clear, 0x03/0x04 interrupt-enable set/clear, 0x05/0x06 overflow set/clear, 0x07 select (bits 4:0), 0x08 indirect count, 0x09 indirect type, 0x0A cycle counter, 0x20+i count of counter i, 0x40+i type of counter i. Other addresses read zero with no error.

## Requirements
- R1: After reset the control word reads 0x0000_0600 (enable 0, implemented count = `HW_LIMIT` = 6), every bitmap reads 0, every counter reads 0, and `irq` is low.
- R2: A control write whose bits 12:8 hold a value from 0 to `HW_LIMIT` sets the implemented count, and that value reads back exactly. A larger value leaves the count unchanged, still updates the enable bit, and gets no error.
- R3: In each bitmap pair, writing 1s to the set address sets those bits and writing 1s to the clear address clears them. Both addresses read back the same current value.
- R4: In every bitmap, bit 31 belongs to the cycle counter and bits below the implemented count belong to event counters. Every other bit reads 0, and writes to it from the bus or from the configuration port (`cfg_sel` 0 count enable, 1 interrupt enable, 2 overflow) are dropped. Lowering the count clears the bits it removes.
- R5: For a counter below the implemented count, its count register stores and returns the written value. Its type register returns bits 15:0 (event number) and bit 31 (privilege exclude) as written, and bits 30:16 read 0.
- R6: The indirect windows at 0x08/0x09 act on the counter named by the select register exactly as the direct addresses do, in any mix of direct and indirect reads and writes.
- R7: A count or type access, direct or indirect, to a counter index at or above the implemented count responds with `rsp_err` = 1 and read data 0, and no register changes.
- R8: A control write with bit 1 set clears all event counters to zero. While the enable bit is 0, no counter advances.
- R9: Event counter i advances by one on a cycle with `evt[i]` high when enable, its count-enable bit and i < implemented count all hold. Wrapping from all-ones to zero sets overflow bit i.
- R10: `irq` is high exactly when some bit is set in both the overflow and the interrupt-enable bitmaps.
- R11: A bus write to a counter in the same cycle as a qualifying event for that counter stores the written value, with no increment and no overflow.
- R12: Every request gets one response beat on the next cycle. Read data reflects the state before any write accepted in the same cycle, and write responses carry data 0.
- R13: The cycle counter advances every cycle while enable and bitmap bit 31 are set. It sets overflow bit 31 on wrap, can be written at 0x0A, and is not cleared by control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat for last cycle's request |
| rsp_err | output | 1 | Access hit an unimplemented counter |
| rsp_rdata | output | 32 | Read data (0 on writes and errors) |
| cfg_we | input | 1 | Load a bitmap from the configuration port |
| cfg_sel | input | 2 | Bitmap chosen: 0 enable, 1 interrupt, 2 overflow |
| cfg_wdata | input | 32 | Bitmap value, masked to live bits |
| evt | input | HW_LIMIT | Per-counter event strobes |
| irq | output | 1 | Overflow interrupt |

## Verification
A wrong implemented count or a leaked bitmap bit shows up on the very next read of any bitmap address, and through `irq` on the cycle after an overflow. A counter that advances when it should not, or misses an event, stays hidden until software reads it. The reference model is compared on every cycle, so a counter is read back after each counting phase to bound that delay. A misrouted indirect access or a missed error shows in the response beat one cycle after the request.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DW      = 32;
  localparam int AW      = 8;
  localparam int IDX_W   = 5;
  localparam int CYC_BIT = 31;

  localparam logic [AW-1:0] A_CTRL  = 8'h00;
  localparam logic [AW-1:0] A_CEN_S = 8'h01;
  localparam logic [AW-1:0] A_CEN_C = 8'h02;
  localparam logic [AW-1:0] A_IEN_S = 8'h03;
  localparam logic [AW-1:0] A_IEN_C = 8'h04;
  localparam logic [AW-1:0] A_OVF_S = 8'h05;
  localparam logic [AW-1:0] A_OVF_C = 8'h06;
  localparam logic [AW-1:0] A_SEL   = 8'h07;
  localparam logic [AW-1:0] A_XCNT  = 8'h08;
  localparam logic [AW-1:0] A_XTYP  = 8'h09;
  localparam logic [AW-1:0] A_CYC   = 8'h0A;
  localparam logic [2:0]    PG_CNT  = 3'b001;
  localparam logic [2:0]    PG_TYP  = 3'b010;

  typedef enum logic [1:0] {BM_CEN = 2'd0, BM_IEN = 2'd1, BM_OVF = 2'd2} bm_sel_e;

  // live bits: cycle bit plus event counters below n
  function automatic logic [DW-1:0] live_mask(input logic [IDX_W-1:0] n);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (IDX_W'(i) < n);
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pmu_bitmap.sv
module pmu_bitmap #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_wdata,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] keep_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] base;

  always_comb begin
    base = q;
    if (set_we) base = base | wdata;
    if (clr_we) base = base & ~wdata;
    if (cfg_we) base = cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (base | hw_set) & keep_mask;
  end

  // R3
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !cfg_we) |=> ((q & $past(wdata) & ~$past(hw_set)) == '0));
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         zap,
  output logic [W-1:0] value,
  output logic         wrap
);
  assign wrap = step && !wr && !zap && (value == '1);

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (zap)  value <= '0;
    else if (wr)   value <= wdata;
    else if (step) value <= value + 1'b1;
  end

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !zap) |=> (value == $past(wdata)));
  // R9
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr && !zap) |=> (value == W'($past(value) + 1'b1)));
endmodule

// File: rtl/pmu_regfile.sv
module pmu_regfile
  import pmu_pkg::*;
#(
  parameter int HW_LIMIT = 6,
  parameter int CTR_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [DW-1:0]       rsp_rdata,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [DW-1:0]       cfg_wdata,
  input  logic [HW_LIMIT-1:0] evt,
  output logic                irq
);
  localparam logic [IDX_W-1:0] N_MAX = IDX_W'(HW_LIMIT);

  logic             en_q;
  logic [IDX_W-1:0] n_q, n_d, sel_q, acc_idx;
  logic [DW-1:0]    cen_q, ien_q, ovf_q, mask_q, mask_d, hw_ovf, rdata_d;
  logic             wr, is_x, acc_cnt, acc_typ, bad, zap;
  logic [CTR_W-1:0] cval [HW_LIMIT];
  logic [CTR_W-1:0] cyc_val;
  logic [16:0]      typ_q [HW_LIMIT];
  logic [HW_LIMIT-1:0] wrap_v;
  logic             cyc_wrap;

  // decode
  assign wr      = req_valid && req_write;
  assign is_x    = (req_addr == A_XCNT) || (req_addr == A_XTYP);
  assign acc_cnt = (req_addr[7:5] == PG_CNT) || (req_addr == A_XCNT);
  assign acc_typ = (req_addr[7:5] == PG_TYP) || (req_addr == A_XTYP);
  assign acc_idx = is_x ? sel_q : req_addr[IDX_W-1:0];
  assign bad     = req_valid && (acc_cnt || acc_typ) && (acc_idx >= n_q);
  assign zap     = wr && (req_addr == A_CTRL) && req_wdata[1];

  always_comb begin
    n_d = n_q;
    if (wr && req_addr == A_CTRL && req_wdata[12:8] <= N_MAX) n_d = req_wdata[12:8];
  end
  assign mask_d = live_mask(n_d);
  assign mask_q = live_mask(n_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      n_q   <= N_MAX;
      sel_q <= '0;
    end else begin
      n_q <= n_d;
      if (wr && req_addr == A_CTRL) en_q  <= req_wdata[0];
      if (wr && req_addr == A_SEL)  sel_q <= req_wdata[IDX_W-1:0];
    end
  end

  // event counters and type registers
  for (genvar i = 0; i < HW_LIMIT; i++) begin : g_ctr
    logic hit;
    assign hit = wr && !bad && (acc_idx == IDX_W'(i));

    pmu_counter #(.W(CTR_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (en_q && cen_q[i] && evt[i] && (IDX_W'(i) < n_q)),
      .wr    (hit && acc_cnt),
      .wdata (req_wdata[CTR_W-1:0]),
      .zap   (zap),
      .value (cval[i]),
      .wrap  (wrap_v[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)              typ_q[i] <= '0;
      else if (hit && acc_typ) typ_q[i] <= {req_wdata[31], req_wdata[15:0]};
    end
  end

  pmu_counter #(.W(CTR_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (en_q && cen_q[CYC_BIT]),
    .wr    (wr && req_addr == A_CYC),
    .wdata (req_wdata[CTR_W-1:0]),
    .zap   (1'b0),
    .value (cyc_val),
    .wrap  (cyc_wrap)
  );

  always_comb begin
    hw_ovf = '0;
    hw_ovf[HW_LIMIT-1:0] = wrap_v;
    hw_ovf[CYC_BIT] = cyc_wrap;
  end

  // bitmaps
  for (genvar b = 0; b < 3; b++) begin : g_bm
    localparam logic [AW-1:0] SET_A = AW'(1 + 2*b);
    logic [DW-1:0] q;
    pmu_bitmap #(.W(DW)) u_bm (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_we    (wr && req_addr == SET_A),
      .clr_we    (wr && req_addr == SET_A + 1'b1),
      .wdata     (req_wdata),
      .cfg_we    (cfg_we && cfg_sel == 2'(b)),
      .cfg_wdata (cfg_wdata),
      .hw_set    ((b == int'(BM_OVF)) ? hw_ovf : '0),
      .keep_mask (mask_d),
      .q         (q)
    );
  end
  assign cen_q = g_bm[0].q;
  assign ien_q = g_bm[1].q;
  assign ovf_q = g_bm[2].q;

  assign irq = |(ovf_q & ien_q);

  // read mux
  always_comb begin
    rdata_d = '0;
    unique case (req_addr)
      A_CTRL:           rdata_d = {19'd0, n_q, 7'd0, en_q};
      A_CEN_S, A_CEN_C: rdata_d = cen_q;
      A_IEN_S, A_IEN_C: rdata_d = ien_q;
      A_OVF_S, A_OVF_C: rdata_d = ovf_q;
      A_SEL:            rdata_d = DW'(sel_q);
      A_CYC:            rdata_d = DW'(cyc_val);
      default: ;
    endcase
    for (int i = 0; i < HW_LIMIT; i++) begin
      if (acc_idx == IDX_W'(i) && !bad) begin
        if (acc_cnt) rdata_d = DW'(cval[i]);
        if (acc_typ) rdata_d = {typ_q[i][16], 15'd0, typ_q[i][15:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= bad;
      rsp_rdata <= (req_valid && !req_write && !bad) ? rdata_d : '0;
    end
  end

  // R2
  n_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) n_q <= N_MAX);
  // R4
  dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cen_q | ien_q | ovf_q) & ~mask_q) == '0);
  // R12
  one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R7
  err_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (rsp_err && rsp_rdata == '0));
endmodule

// File: tb/tb_pmu_regfile.sv
module tb_pmu_regfile;
  localparam int L = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, irq;
  logic [31:0] rsp_rdata;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [L-1:0] evt = '0;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  pmu_regfile #(.HW_LIMIT(L), .CTR_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .evt(evt), .irq(irq));

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic        m_en;
  int          m_n, m_sel;
  logic [31:0] m_cnt [L];
  logic [31:0] m_typ [L];
  logic [31:0] m_cyc, m_cen, m_ien, m_ovf;
  logic        e_valid, e_err;
  logic [31:0] e_rdata;

  function automatic logic [31:0] live(input int n);
    logic [31:0] m = 32'h8000_0000;
    for (int i = 0; i < 31; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_n = L; m_sel = 0; m_cyc = 0;
      m_cen = 0; m_ien = 0; m_ovf = 0;
      for (int i = 0; i < L; i++) begin m_cnt[i] = 0; m_typ[i] = 0; end
      e_valid = 0; e_err = 0; e_rdata = 0;
    end else begin
      logic w, xc, xt, ac, at, bad, zap;
      int idx, n_new;
      logic [31:0] ovf_hw, rd, base;
      w  = req_valid && req_write;
      xc = (req_addr == 8'h08); xt = (req_addr == 8'h09);
      ac = (req_addr >= 8'h20 && req_addr < 8'h40) || xc;
      at = (req_addr >= 8'h40 && req_addr < 8'h60) || xt;
      idx = (xc || xt) ? m_sel : int'(req_addr[4:0]);
      bad = req_valid && (ac || at) && (idx >= m_n);
      rd = 0;
      if (ac && !bad) rd = m_cnt[idx];
      else if (at && !bad) rd = m_typ[idx];
      else case (req_addr)
        8'h00: rd = (32'(m_n) << 8) | 32'(m_en);
        8'h01, 8'h02: rd = m_cen;
        8'h03, 8'h04: rd = m_ien;
        8'h05, 8'h06: rd = m_ovf;
        8'h07: rd = 32'(m_sel);
        8'h0A: rd = m_cyc;
        default: rd = 0;
      endcase
      e_valid = req_valid; e_err = bad;
      e_rdata = (req_valid && !req_write && !bad) ? rd : 0;
      // state update from old state
      zap = w && req_addr == 8'h00 && req_wdata[1];
      ovf_hw = 0;
      for (int i = 0; i < L; i++) begin
        logic hitw, stp;
        hitw = w && ac && !bad && idx == i;
        stp  = m_en && m_cen[i] && evt[i] && i < m_n;
        if (zap) m_cnt[i] = 0;
        else if (hitw) m_cnt[i] = req_wdata;
        else if (stp) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) ovf_hw[i] = 1'b1;
          m_cnt[i] = m_cnt[i] + 1;
        end
        if (w && at && !bad && idx == i) m_typ[i] = req_wdata & 32'h8000_FFFF;
      end
      if (w && req_addr == 8'h0A) m_cyc = req_wdata;
      else if (m_en && m_cen[31]) begin
        if (m_cyc == 32'hFFFF_FFFF) ovf_hw[31] = 1'b1;
        m_cyc = m_cyc + 1;
      end
      n_new = m_n;
      if (w && req_addr == 8'h00) begin
        if (int'(req_wdata[12:8]) <= L) n_new = int'(req_wdata[12:8]);
        m_en = req_wdata[0];
      end
      if (w && req_addr == 8'h07) m_sel = int'(req_wdata[4:0]);
      base = m_cen;
      if (w && req_addr == 8'h01) base = base | req_wdata;
      if (w && req_addr == 8'h02) base = base & ~req_wdata;
      if (cfg_we && cfg_sel == 0) base = cfg_wdata;
      m_cen = base & live(n_new);
      base = m_ien;
      if (w && req_addr == 8'h03) base = base | req_wdata;
      if (w && req_addr == 8'h04) base = base & ~req_wdata;
      if (cfg_we && cfg_sel == 1) base = cfg_wdata;
      m_ien = base & live(n_new);
      base = m_ovf;
      if (w && req_addr == 8'h05) base = base | req_wdata;
      if (w && req_addr == 8'h06) base = base & ~req_wdata;
      if (cfg_we && cfg_sel == 2) base = cfg_wdata;
      m_ovf = (base | ovf_hw) & live(n_new);
      m_n = n_new;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({tag, " R12 rsp_valid"}, 32'(rsp_valid), 32'(e_valid));
      chk({tag, " R7 rsp_err"},    32'(rsp_err),   32'(e_err));
      chk({tag, " R12 rsp_rdata"}, rsp_rdata,      e_rdata);
      chk({tag, " R10 irq"},       32'(irq),       32'(|(m_ovf & m_ien)));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc(1'b1, a, d);
    chk({tag, " write no error"}, 32'(rsp_err), 32'd0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string t);
    acc(1'b0, a, 32'd0);
    chk(t, rsp_rdata, exp);
  endtask

  task automatic bad_acc(input logic w, input logic [7:0] a, input string t);
    acc(w, a, 32'h5A5A_5A5A);
    chk({t, " err"}, 32'(rsp_err), 32'd1);
    chk({t, " data"}, rsp_rdata, 32'd0);
  endtask

  task automatic pulse(input logic [L-1:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tag = "R1";
    chk("R1 irq low", 32'(irq), 32'd0);
    rd(8'h00, 32'h0000_0600, "R1 control");
    rd(8'h01, 32'h0, "R1 enable bitmap");
    rd(8'h22, 32'h0, "R1 counter");
    // R2 implemented count
    tag = "R2";
    wr(8'h00, 32'h0000_0300); rd(8'h00, 32'h0000_0300, "R2 n=3");
    wr(8'h00, 32'h0000_0700); rd(8'h00, 32'h0000_0300, "R2 n=7 refused");
    wr(8'h00, 32'h0000_0000); rd(8'h00, 32'h0000_0000, "R2 n=0");
    wr(8'h00, 32'h0000_0600); rd(8'h00, 32'h0000_0600, "R2 n=6");
    // R3 set/clear
    tag = "R3";
    wr(8'h01, 32'h5); rd(8'h01, 32'h5, "R3 set read"); rd(8'h02, 32'h5, "R3 clr read");
    wr(8'h02, 32'h1); rd(8'h01, 32'h4, "R3 after clear");
    wr(8'h03, 32'h8000_0002); rd(8'h04, 32'h8000_0002, "R3 inten pair");
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h02, 32'hFFFF_FFFF);
    // R4 dead bits
    tag = "R4";
    wr(8'h00, 32'h0000_0300);
    wr(8'h01, 32'hFFFF_FFFF); rd(8'h02, 32'h8000_0007, "R4 bus set masked");
    @(negedge clk); cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); cfg_we = 1'b0;
    rd(8'h03, 32'h8000_0007, "R4 cfg masked");
    wr(8'h00, 32'h0000_0200); rd(8'h01, 32'h8000_0003, "R4 shrink drops bits");
    wr(8'h00, 32'h0000_0300); rd(8'h01, 32'h8000_0003, "R4 regrow stays clear");
    wr(8'h02, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
    // R5 direct access
    tag = "R5";
    wr(8'h00, 32'h0000_0600);
    wr(8'h22, 32'h0001_2347); rd(8'h22, 32'h0001_2347, "R5 count direct");
    wr(8'h42, 32'h8000_0008); rd(8'h42, 32'h8000_0008, "R5 type exclude+event");
    wr(8'h43, 32'h7FFF_003F); rd(8'h43, 32'h0000_003F, "R5 type upper bits drop");
    // R6 indirect
    tag = "R6";
    wr(8'h07, 32'd2); rd(8'h08, 32'h0001_2347, "R6 indirect read count");
    wr(8'h08, 32'h0000_0ABC); rd(8'h22, 32'h0000_0ABC, "R6 direct sees indirect");
    rd(8'h09, 32'h8000_0008, "R6 indirect type");
    wr(8'h09, 32'h0000_0011); rd(8'h42, 32'h0000_0011, "R6 type mix");
    // R7 unimplemented
    tag = "R7";
    wr(8'h25, 32'h0000_0055);
    wr(8'h00, 32'h0000_0400);
    bad_acc(1'b0, 8'h24, "R7 direct read");
    bad_acc(1'b1, 8'h25, "R7 direct write");
    bad_acc(1'b1, 8'h45, "R7 type write");
    wr(8'h07, 32'd5);
    bad_acc(1'b1, 8'h08, "R7 indirect write");
    bad_acc(1'b0, 8'h09, "R7 indirect type read");
    bad_acc(1'b0, 8'h3F, "R7 index 31");
    wr(8'h00, 32'h0000_0600);
    rd(8'h25, 32'h0000_0055, "R7 value untouched");
    rd(8'h45, 32'h0000_0000, "R7 type untouched");
    // R8 clear-all
    tag = "R8";
    wr(8'h00, 32'h0000_0602);
    rd(8'h22, 32'h0, "R8 counter cleared"); rd(8'h25, 32'h0, "R8 counter5 cleared");
    rd(8'h00, 32'h0000_0600, "R8 clear bit reads 0");
    // R9 counting
    tag = "R9";
    wr(8'h01, 32'h3); wr(8'h00, 32'h0000_0601);
    pulse(6'b000001); pulse(6'b000011); pulse(6'b000001); pulse(6'b000100);
    wr(8'h00, 32'h0000_0600);
    rd(8'h20, 32'd3, "R9 counter0"); rd(8'h21, 32'd1, "R9 counter1");
    rd(8'h22, 32'd0, "R9 disabled-bit counter2");
    tag = "R8";
    pulse(6'b000011);
    rd(8'h20, 32'd3, "R8 no count while disabled");
    tag = "R9";
    wr(8'h21, 32'hFFFF_FFFF); wr(8'h00, 32'h0000_0601);
    pulse(6'b000010); wr(8'h00, 32'h0000_0600);
    rd(8'h21, 32'd0, "R9 wrapped"); rd(8'h05, 32'h2, "R9 overflow bit");
    // R10 interrupt
    tag = "R10";
    wr(8'h03, 32'h2); chk("R10 irq high", 32'(irq), 32'd1);
    wr(8'h06, 32'h2); chk("R10 irq low", 32'(irq), 32'd0);
    wr(8'h04, 32'h2);
    // R11 write beats event
    tag = "R11";
    wr(8'h00, 32'h0000_0601);
    @(negedge clk);
    evt = 6'b000001; req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h20; req_wdata = 32'h100;
    @(negedge clk);
    evt = '0; req_valid = 1'b0; req_write = 1'b0;
    wr(8'h00, 32'h0000_0600);
    rd(8'h20, 32'h100, "R11 write wins");
    // R13 cycle counter
    tag = "R13";
    wr(8'h0A, 32'hFFFF_FFFD); wr(8'h01, 32'h8000_0000);
    wr(8'h00, 32'h0000_0601); repeat (4) @(negedge clk); wr(8'h00, 32'h0000_0600);
    rd(8'h05, 32'h8000_0000, "R13 cycle overflow");
    wr(8'h02, 32'h8000_0000);
    acc(1'b0, 8'h0A, 32'd0); v = rsp_rdata;
    chk("R13 cycle advanced", 32'(v != 0 && v < 32'd20), 32'd1);
    wr(8'h00, 32'h0000_0602);
    rd(8'h0A, v, "R13 not cleared by clear-all");
    tag = "R12";
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule